// File: doc/BRIEF.md
# SDRAM Byte-Lane Mask Timing Unit

This unit sits between the command/data pipeline of a synchronous DRAM and its storage array and pad drivers. It applies active-high byte-lane masks that have two different timings. On a write beat the mask takes effect in the same clock period: it decides which lanes of the incoming beat reach the array. On a read the same mask pins act two clock periods later, as an output enable for the data drivers.

The design therefore keeps two independent paths. The write path is purely combinational. The read path is a reset-cleared shift line per lane, which samples the mask pins every period whatever the current mode. A `DQ_WIDTH` parameter selects a 4-, 8- or 16-bit word. At 16 bits the word has two byte lanes, each with its own mask. At 4 and 8 bits the lower mask alone covers the whole word. The drivers are also switched off in any period that carries no valid read data, whatever the mask says.

Top module: `dqm_timing_unit`

## Requirements
- R1: While reset is low, and afterwards until masks sampled after reset have travelled through the delay line, every bit of `drv_oe` is 0. The delay line resets to the masked state.
- R2: In a period where `wr_mode` is 1, `arr_we[l]` equals the inverse of lane l's mask in that same period. `arr_wdata` carries `wr_data` on enabled lanes and zero on blocked lanes.
- R3: In a period where `wr_mode` is 0, `arr_we` is all zero and `arr_wdata` is zero, whatever the masks are.
- R4: In a period where `rd_valid` is 1, `drv_oe[l]` is the inverse of lane l's mask as it was presented two clock periods earlier.
- R5: In a period where `rd_valid` is 0, `drv_oe` is all zero, whatever the masks are.
- R6: `drv_data` carries `rd_data` on lanes whose `drv_oe` bit is 1 and zero on the other lanes.
- R7: With `DQ_WIDTH`=16 there are two lanes. Lane 0 is bits 7:0 and is governed by `mask_lo`. Lane 1 is bits 15:8 and is governed by `mask_hi`.
- R8: With `DQ_WIDTH` of 4 or 8 there is a single lane covering the whole word. That lane is governed by `mask_lo`, and `mask_hi` has no effect on any output.
- R9: The read delay line samples the mask pins in every period, including write periods. A mask presented during a write beat therefore sets the output enable of a read two periods later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_lo | input | 1 | Lower lane mask, 1 blocks |
| mask_hi | input | 1 | Upper lane mask, 1 blocks (16-bit only) |
| wr_mode | input | 1 | 1 = this period is a write beat |
| wr_data | input | DQ_WIDTH | Write beat data from the bus |
| rd_valid | input | 1 | 1 = read data from the array is valid this period |
| rd_data | input | DQ_WIDTH | Read data from the array |
| arr_we | output | LANES | Per-lane write enable to the array |
| arr_wdata | output | DQ_WIDTH | Lane-gated write data to the array |
| drv_oe | output | LANES | Per-lane output enable for the data drivers |
| drv_data | output | DQ_WIDTH | Lane-gated read data to the drivers |

## Verification
A write beat and a read data period can share one clock period, as happens at a read-to-write turnaround. In that period the write enable follows the mask present now, while the driver enable follows the mask from two periods before. The bench provokes this by asserting `wr_mode` and `rd_valid` together while the mask changes from period to period. It also applies a mask during a write beat and then reads two periods later. The bench keeps its own two-deep history of lane masks, and it judges both outputs of that shared period against the present mask and against the delayed mask respectively. A second instance at 8 bits runs the same stimulus, so that upper-mask activity is shown to leave its outputs unchanged.

// File: rtl/dqm_pkg.sv
package dqm_pkg;

  localparam int MAX_DQ     = 16;
  localparam int WIDE_LANES = 2;

  // number of independently masked lanes for a given word width
  function automatic int lane_count(input int dq_width);
    return (dq_width == 16) ? WIDE_LANES : 1;
  endfunction

  // bits per lane
  function automatic int lane_bits(input int dq_width);
    return dq_width / lane_count(dq_width);
  endfunction

  // a lane is enabled for writing when the beat is a write and it is unmasked
  function automatic logic write_allow(input logic wr_mode, input logic lane_masked);
    return wr_mode & ~lane_masked;
  endfunction

  // a lane drives when read data is valid and its delayed mask is low
  function automatic logic drive_allow(input logic rd_valid, input logic late_mask);
    return rd_valid & ~late_mask;
  endfunction

endpackage

// File: rtl/dqm_lane_map.sv
module dqm_lane_map #(
  parameter int DQ_WIDTH = 16,
  localparam int LANES   = dqm_pkg::lane_count(DQ_WIDTH)
) (
  input  logic             mask_lo,
  input  logic             mask_hi,
  output logic [LANES-1:0] lane_mask
);

  generate
    if (LANES == 2) begin : g_wide
      assign lane_mask = {mask_hi, mask_lo};
    end else begin : g_narrow
      logic unused_mask_hi;
      assign unused_mask_hi = mask_hi;
      assign lane_mask      = mask_lo;
    end
  endgenerate

endmodule

// File: rtl/dqm_wr_gate.sv
module dqm_wr_gate #(
  parameter int DQ_WIDTH = 16,
  localparam int LANES   = dqm_pkg::lane_count(DQ_WIDTH),
  localparam int LW      = dqm_pkg::lane_bits(DQ_WIDTH)
) (
  input  logic                wr_mode,
  input  logic [LANES-1:0]    lane_mask,
  input  logic [DQ_WIDTH-1:0] wr_data,
  output logic [LANES-1:0]    wr_en,
  output logic [DQ_WIDTH-1:0] wr_out
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wr_en[l]            = dqm_pkg::write_allow(wr_mode, lane_mask[l]);
    assign wr_out[l*LW +: LW]  = wr_en[l] ? wr_data[l*LW +: LW] : '0;
  end

endmodule

// File: rtl/dqm_rd_delay.sv
module dqm_rd_delay #(
  parameter int LANES  = 2,
  parameter int RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_mask,
  output logic [LANES-1:0] late_mask
);

  logic [LANES-1:0] stage_q [RD_LAT];

  for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
    logic [LANES-1:0] stage_d;
    if (s == 0) begin : g_head
      assign stage_d = lane_mask;
    end else begin : g_body
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '1;
      else        stage_q[s] <= stage_d;
    end
  end

  assign late_mask = stage_q[RD_LAT-1];

endmodule

// File: rtl/dqm_timing_unit.sv
module dqm_timing_unit #(
  parameter int DQ_WIDTH = 16,
  parameter int RD_LAT   = 2,
  localparam int LANES   = dqm_pkg::lane_count(DQ_WIDTH),
  localparam int LW      = dqm_pkg::lane_bits(DQ_WIDTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mask_lo,
  input  logic                mask_hi,
  input  logic                wr_mode,
  input  logic [DQ_WIDTH-1:0] wr_data,
  input  logic                rd_valid,
  input  logic [DQ_WIDTH-1:0] rd_data,
  output logic [LANES-1:0]    arr_we,
  output logic [DQ_WIDTH-1:0] arr_wdata,
  output logic [LANES-1:0]    drv_oe,
  output logic [DQ_WIDTH-1:0] drv_data
);

  // named internal events
  logic [LANES-1:0] lane_mask;
  logic [LANES-1:0] late_mask;

  dqm_lane_map #(.DQ_WIDTH(DQ_WIDTH)) u_map (
    .mask_lo   (mask_lo),
    .mask_hi   (mask_hi),
    .lane_mask (lane_mask)
  );

  dqm_wr_gate #(.DQ_WIDTH(DQ_WIDTH)) u_wr (
    .wr_mode   (wr_mode),
    .lane_mask (lane_mask),
    .wr_data   (wr_data),
    .wr_en     (arr_we),
    .wr_out    (arr_wdata)
  );

  dqm_rd_delay #(.LANES(LANES), .RD_LAT(RD_LAT)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_mask (lane_mask),
    .late_mask (late_mask)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_drv
    assign drv_oe[l]             = dqm_pkg::drive_allow(rd_valid, late_mask[l]);
    assign drv_data[l*LW +: LW]  = drv_oe[l] ? rd_data[l*LW +: LW] : '0;
  end

endmodule

// File: rtl/dqm_timing_chk.sv
module dqm_timing_chk #(
  parameter int DQ_WIDTH = 16,
  parameter int LANES    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_mode,
  input logic                rd_valid,
  input logic [LANES-1:0]    lane_mask,
  input logic [LANES-1:0]    arr_we,
  input logic [LANES-1:0]    drv_oe,
  input logic [DQ_WIDTH-1:0] drv_data
);
  localparam int LW = DQ_WIDTH / LANES;

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2) since_rst <= since_rst + 2'd1;
  end

  p_oe_off_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 0) |-> (drv_oe == '0));

  p_we_follows_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |-> (arr_we == ~lane_mask));

  p_we_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |-> (arr_we == '0));

  p_oe_delayed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2 && rd_valid) |-> (drv_oe == ~$past(lane_mask, 2)));

  p_oe_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (drv_oe == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    p_data_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_oe[l] |-> (drv_data[l*LW +: LW] == '0));
  end

endmodule

bind dqm_timing_unit dqm_timing_chk #(.DQ_WIDTH(DQ_WIDTH), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_mode   (wr_mode),
  .rd_valid  (rd_valid),
  .lane_mask (lane_mask),
  .arr_we    (arr_we),
  .drv_oe    (drv_oe),
  .drv_data  (drv_data)
);

// File: tb/sim_dqm_timing_unit.sv
module sim_dqm_timing_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mask_lo = 1'b1, mask_hi = 1'b1, wr_mode = 1'b0, rd_valid = 1'b0;
  logic [15:0] wr_data = '0, rd_data = '0;

  logic [1:0]  we16, oe16;
  logic [15:0] wd16, dd16;
  logic [0:0]  we8, oe8;
  logic [7:0]  wd8, dd8;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dqm_timing_unit #(.DQ_WIDTH(16)) u0 (
    .clk(clk), .rst_n(rst_n), .mask_lo(mask_lo), .mask_hi(mask_hi),
    .wr_mode(wr_mode), .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .arr_we(we16), .arr_wdata(wd16), .drv_oe(oe16), .drv_data(dd16));

  dqm_timing_unit #(.DQ_WIDTH(8)) u1 (
    .clk(clk), .rst_n(rst_n), .mask_lo(mask_lo), .mask_hi(mask_hi),
    .wr_mode(wr_mode), .wr_data(wr_data[7:0]), .rd_valid(rd_valid), .rd_data(rd_data[7:0]),
    .arr_we(we8), .arr_wdata(wd8), .drv_oe(oe8), .drv_data(dd8));

  typedef struct {
    logic [1:0]  we16, oe16;
    logic [15:0] wd16, dd16;
    logic        we8, oe8;
    logic [7:0]  wd8, dd8;
    bit          wr, rv, via_write;
  } exp_t;

  exp_t q[$];

  // bench-side mask history, reset value = masked
  logic [1:0] h1 = 2'b11, h2 = 2'b11;
  logic       n1 = 1'b1,  n2 = 1'b1;
  bit         w1 = 0, w2 = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic beat(input bit wm, input bit mlo, input bit mhi,
                      input logic [15:0] wd, input bit rv, input logic [15:0] rd);
    exp_t e;
    logic [1:0] lm;
    @(negedge clk);
    wr_mode = wm; mask_lo = mlo; mask_hi = mhi; wr_data = wd; rd_valid = rv; rd_data = rd;
    lm = {mhi, mlo};
    e.we16 = wm ? ~lm : 2'b00;
    e.wd16 = {e.we16[1] ? wd[15:8] : 8'h00, e.we16[0] ? wd[7:0] : 8'h00};
    e.oe16 = rv ? ~h2 : 2'b00;
    e.dd16 = {e.oe16[1] ? rd[15:8] : 8'h00, e.oe16[0] ? rd[7:0] : 8'h00};
    e.we8  = wm & ~mlo;
    e.wd8  = e.we8 ? wd[7:0] : 8'h00;
    e.oe8  = rv & ~n2;
    e.dd8  = e.oe8 ? rd[7:0] : 8'h00;
    e.wr = wm; e.rv = rv; e.via_write = w2;
    q.push_back(e);
    h2 = h1; h1 = lm; n2 = n1; n1 = mlo; w2 = w1; w1 = wm;
  endtask

  // monitor: compare just before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.wr ? "R2/R7 we16" : "R3 we16", {14'd0, we16}, {14'd0, e.we16});
        chk(e.wr ? "R2/R7 wdata16" : "R3 wdata16", wd16, e.wd16);
        chk(!e.rv ? "R5 oe16" : (e.via_write ? "R9 oe16" : "R4/R7 oe16"),
            {14'd0, oe16}, {14'd0, e.oe16});
        chk("R6 rdata16", dd16, e.dd16);
        chk("R8 we8", {15'd0, we8}, {15'd0, e.we8});
        chk("R8 wdata8", {8'd0, wd8}, {8'd0, e.wd8});
        chk("R8 oe8", {15'd0, oe8}, {15'd0, e.oe8});
        chk("R8 rdata8", {8'd0, dd8}, {8'd0, e.dd8});
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: in reset, drivers stay off even with valid data and low masks
    #12;
    mask_lo = 1'b0; mask_hi = 1'b0; rd_valid = 1'b1; rd_data = 16'hA55A;
    @(negedge clk); #2;
    chk("R1 oe16 in reset", {14'd0, oe16}, 16'd0);
    chk("R1 oe8 in reset", {15'd0, oe8}, 16'd0);
    mask_lo = 1'b1; mask_hi = 1'b1; rd_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R1/R4: first two reads after reset stay off, third follows the mask
    beat(0, 0, 0, 16'h0000, 1, 16'h1234);
    beat(0, 0, 0, 16'h0000, 1, 16'h5678);
    beat(0, 0, 0, 16'h0000, 1, 16'h9ABC);
    // R4/R7: per-lane read masks
    beat(0, 1, 0, 16'h0000, 1, 16'h1111);
    beat(0, 0, 1, 16'h0000, 1, 16'h2222);
    beat(0, 0, 0, 16'h0000, 1, 16'h3333);
    beat(0, 1, 1, 16'h0000, 1, 16'h4444);
    beat(0, 0, 0, 16'h0000, 1, 16'h5555);
    beat(0, 0, 0, 16'h0000, 1, 16'h6666);
    // R5: no valid data
    beat(0, 0, 0, 16'h0000, 0, 16'h7777);
    beat(0, 1, 0, 16'h0000, 0, 16'h8888);
    // R2/R7: write beats with every mask pair
    beat(1, 0, 0, 16'hC3C3, 0, 16'h0000);
    beat(1, 1, 0, 16'hBEEF, 0, 16'h0000);
    beat(1, 0, 1, 16'hCAFE, 0, 16'h0000);
    beat(1, 1, 1, 16'hF00D, 0, 16'h0000);
    // R9 and collision: write beats with reads in the same period
    beat(1, 0, 1, 16'h1357, 1, 16'h2468);
    beat(1, 1, 0, 16'h9753, 1, 16'h8642);
    beat(0, 0, 0, 16'hFFFF, 1, 16'hAAAA);
    beat(0, 0, 0, 16'hFFFF, 1, 16'hBBBB);
    // R3: masks toggling outside write mode
    beat(0, 1, 1, 16'hDEAD, 0, 16'h0000);
    beat(0, 0, 0, 16'hDEAD, 0, 16'h0000);
    // R8: upper mask only, narrow instance must ignore it
    beat(1, 0, 1, 16'h00A5, 1, 16'h005A);
    beat(0, 0, 1, 16'h0000, 1, 16'h00C3);
    beat(0, 0, 1, 16'h0000, 1, 16'h003C);
    beat(0, 1, 0, 16'h0000, 1, 16'h0099);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule